// File: doc/BRIEF.md
# Iterative multiply/divide unit with result register pair

This block owns a pair of result registers, an upper half and a lower half, and drives them from a sequential arithmetic engine. A 6-bit function code arrives with a start strobe and two operands. The code selects one of four jobs: a signed or unsigned multiply, or a signed or unsigned divide. Each job runs for a fixed number of iteration cycles, one per operand bit. A multiply uses a shift-and-add core and a divide uses a restoring core. While a job runs, a busy flag is high. On the last iteration cycle both halves of the pair are written at the same edge.

The same function-code input also selects moves. A move-to loads one half of the pair from the first operand. A move-from returns one half on a read-data port, qualified by a one-cycle valid pulse. The pair has no other access path. Both halves are also visible at all times on dedicated output ports.

If a move-from arrives while a job is running, it is held. It is answered at the edge where the job writes its result, so it always returns the final value. Any other request made while busy is dropped. A divide by zero runs the normal number of cycles and never stalls the unit.

Top module: `mdu_hilo`

## Requirements
- R1: A synchronous reset clears the upper half, the lower half, busy and the read-valid pulse.
- R2: Function code 011001 multiplies the operands as unsigned numbers. The upper 32 bits of the 64-bit product go to the upper half and the lower 32 bits go to the lower half.
- R3: Function code 011000 multiplies the operands as two's-complement numbers and places the 64-bit signed product the same way as R2.
- R4: Function code 011011 divides the first operand by the second as unsigned numbers. The quotient goes to the lower half and the remainder goes to the upper half.
- R5: Function code 011010 divides as two's-complement numbers. The quotient truncates toward zero and the remainder takes the sign of the dividend. The quotient goes to the lower half and the remainder goes to the upper half.
- R6: Busy rises at the edge that accepts a multiply or divide and stays high for exactly WIDTH (32) cycles. Both halves keep their values while busy, and both change at the edge where busy falls.
- R7: When idle, code 010001 loads the upper half from the first operand and code 010011 loads the lower half from the first operand. The load happens at the next edge and leaves the other half unchanged.
- R8: When idle, code 010000 returns the upper half and code 010010 returns the lower half on the read-data port. The value appears with a one-cycle read-valid pulse at the next edge.
- R9: A move-from request made while busy is held. It is answered with a read-valid pulse at the edge where busy falls, and the value returned is the final result half.
- R10: While busy, a start with any code other than a move-from has no effect. When idle, a start with a code outside the eight listed codes has no effect.
- R11: A divide by zero completes in WIDTH cycles, like any other divide, and the unit then accepts the next operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, sampled each cycle |
| func | input | 6 | Function code selecting the operation |
| opa | input | 32 | First operand: dividend, multiplicand or move source |
| opb | input | 32 | Second operand: divisor or multiplier |
| busy | output | 1 | High while a multiply or divide is iterating |
| hi | output | 32 | Upper-half result register |
| lo | output | 32 | Lower-half result register |
| rd_valid | output | 1 | One-cycle pulse qualifying rd_data |
| rd_data | output | 32 | Value returned by a move-from request |

## Verification
A corrupted iteration counter shows at the busy port at once. The falling edge of busy would come at a cycle other than WIDTH cycles after the start, and the cycle-by-cycle comparison catches it at that edge. Wrong magnitude, sign-correction or shift state stays hidden until the completion edge. At that edge it appears on hi, lo and any held read. For this reason the bench makes sure every sign combination, the most negative operand and a result with all bits set each reach a completion edge. A lost or early held read shows as a read-valid pulse that is missing, or that arrives in the wrong cycle with a stale value.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   localparam logic [5:0] FN_RD_HI = 6'b010000;
   localparam logic [5:0] FN_WR_HI = 6'b010001;
   localparam logic [5:0] FN_RD_LO = 6'b010010;
   localparam logic [5:0] FN_WR_LO = 6'b010011;
   localparam logic [5:0] FN_MUL_S = 6'b011000;
   localparam logic [5:0] FN_MUL_U = 6'b011001;
   localparam logic [5:0] FN_DIV_S = 6'b011010;
   localparam logic [5:0] FN_DIV_U = 6'b011011;

   typedef struct packed {
      logic run_mul;
      logic run_div;
      logic sgn;
      logic wr_hi;
      logic wr_lo;
      logic rd_hi;
      logic rd_lo;
   } op_dec_t;

endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
   import mdu_pkg::*;
(
   input  logic       valid,
   input  logic [5:0] fn,
   output op_dec_t    dec
);

   always_comb begin
      dec = '0;
      if (valid) begin
         case (fn)
            FN_MUL_S: begin dec.run_mul = 1'b1; dec.sgn = 1'b1; end
            FN_MUL_U: dec.run_mul = 1'b1;
            FN_DIV_S: begin dec.run_div = 1'b1; dec.sgn = 1'b1; end
            FN_DIV_U: dec.run_div = 1'b1;
            FN_WR_HI: dec.wr_hi = 1'b1;
            FN_WR_LO: dec.wr_lo = 1'b1;
            FN_RD_HI: dec.rd_hi = 1'b1;
            FN_RD_LO: dec.rd_lo = 1'b1;
            default:  dec = '0;
         endcase
      end
   end

endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           load,
   input  logic           step,
   input  logic [W-1:0]   mcand_in,
   input  logic [W-1:0]   mplier_in,
   output logic [2*W-1:0] prod_nxt
);

   logic [W-1:0]   mcand_q;
   logic [2*W-1:0] prod_q;
   logic [W:0]     upper_sum;

   always_comb begin
      upper_sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
      prod_nxt  = {upper_sum, prod_q[W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (load) begin
         mcand_q <= mcand_in;
         prod_q  <= {{W{1'b0}}, mplier_in};
      end else if (step) begin
         prod_q  <= prod_nxt;
      end
   end

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         step,
   input  logic         last,
   input  logic [W-1:0] dvd_in,
   input  logic [W-1:0] dvs_in,
   output logic [W-1:0] quo_nxt,
   output logic [W-1:0] rem_nxt
);

   logic [W-1:0] dvs_q;
   logic [W-1:0] rem_q;
   logic [W-1:0] quo_q;
   logic [W:0]   shifted;
   logic [W-1:0] trial;
   logic         fits;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      fits    = shifted >= {1'b0, dvs_q};
      trial   = shifted[W-1:0] - dvs_q;
      rem_nxt = fits ? trial : shifted[W-1:0];
      quo_nxt = {quo_q[W-2:0], fits};
   end

   always_ff @(posedge clk) begin
      if (load) begin
         dvs_q <= dvs_in;
         rem_q <= '0;
         quo_q <= dvd_in;
      end else if (step) begin
         rem_q <= rem_nxt;
         quo_q <= quo_nxt;
      end
   end

   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
      (last && dvs_q != '0) |-> (rem_nxt < dvs_q)); // R4

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
   import mdu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [5:0]       func,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic             busy,
   output logic [WIDTH-1:0] hi,
   output logic [WIDTH-1:0] lo,
   output logic             rd_valid,
   output logic [WIDTH-1:0] rd_data
);

   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] CNT_INIT = CW'(WIDTH - 1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("mdu_hilo: WIDTH must be at least 2");
      end
   endgenerate

   op_dec_t          dec;
   logic             accept;
   logic             busy_q;
   logic [CW-1:0]    cnt_q;
   logic             is_div_q;
   logic             neg_res_q;
   logic             neg_rem_q;
   logic             pend_q;
   logic             pend_hi_q;
   logic [WIDTH-1:0] hi_q;
   logic [WIDTH-1:0] lo_q;
   logic             rdv_q;
   logic [WIDTH-1:0] rdd_q;

   logic [WIDTH-1:0]   mag_a;
   logic [WIDTH-1:0]   mag_b;
   logic               last;
   logic               busy_rd;
   logic               busy_rd_hi;
   logic [2*WIDTH-1:0] prod_nxt;
   logic [2*WIDTH-1:0] prod_fix;
   logic [WIDTH-1:0]   quo_nxt;
   logic [WIDTH-1:0]   rem_nxt;
   logic [WIDTH-1:0]   quo_fix;
   logic [WIDTH-1:0]   rem_fix;
   logic [WIDTH-1:0]   fin_hi;
   logic [WIDTH-1:0]   fin_lo;

   assign accept = start && !busy_q;

   mdu_decode u_decode (
      .valid (accept),
      .fn    (func),
      .dec   (dec)
   );

   always_comb begin
      mag_a      = (dec.sgn && opa[WIDTH-1]) ? (~opa + 1'b1) : opa;
      mag_b      = (dec.sgn && opb[WIDTH-1]) ? (~opb + 1'b1) : opb;
      last       = busy_q && (cnt_q == '0);
      busy_rd    = start && busy_q && ((func == FN_RD_HI) || (func == FN_RD_LO));
      busy_rd_hi = (func == FN_RD_HI);
   end

   mdu_mul_core #(.W(WIDTH)) u_mul (
      .clk       (clk),
      .load      (dec.run_mul),
      .step      (busy_q),
      .mcand_in  (mag_a),
      .mplier_in (mag_b),
      .prod_nxt  (prod_nxt)
   );

   mdu_div_core #(.W(WIDTH)) u_div (
      .clk     (clk),
      .rst     (rst),
      .load    (dec.run_div),
      .step    (busy_q),
      .last    (last),
      .dvd_in  (mag_a),
      .dvs_in  (mag_b),
      .quo_nxt (quo_nxt),
      .rem_nxt (rem_nxt)
   );

   always_comb begin
      prod_fix = neg_res_q ? (~prod_nxt + 1'b1) : prod_nxt;
      quo_fix  = neg_res_q ? (~quo_nxt + 1'b1) : quo_nxt;
      rem_fix  = neg_rem_q ? (~rem_nxt + 1'b1) : rem_nxt;
      fin_hi   = is_div_q ? rem_fix : prod_fix[2*WIDTH-1:WIDTH];
      fin_lo   = is_div_q ? quo_fix : prod_fix[WIDTH-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
         is_div_q  <= 1'b0;
         neg_res_q <= 1'b0;
         neg_rem_q <= 1'b0;
         pend_q    <= 1'b0;
         pend_hi_q <= 1'b0;
         hi_q      <= '0;
         lo_q      <= '0;
         rdv_q     <= 1'b0;
         rdd_q     <= '0;
      end else begin
         rdv_q <= 1'b0;
         if (last) begin
            busy_q <= 1'b0;
            hi_q   <= fin_hi;
            lo_q   <= fin_lo;
            pend_q <= 1'b0;
            if (pend_q || busy_rd) begin
               rdv_q <= 1'b1;
               if (busy_rd ? busy_rd_hi : pend_hi_q) rdd_q <= fin_hi;
               else                                  rdd_q <= fin_lo;
            end
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (busy_rd) begin
               pend_q    <= 1'b1;
               pend_hi_q <= busy_rd_hi;
            end
         end else begin
            if (dec.run_mul || dec.run_div) begin
               busy_q    <= 1'b1;
               cnt_q     <= CNT_INIT;
               is_div_q  <= dec.run_div;
               neg_res_q <= dec.sgn && (opa[WIDTH-1] ^ opb[WIDTH-1]);
               neg_rem_q <= dec.sgn && opa[WIDTH-1];
            end
            if (dec.wr_hi) hi_q <= opa;
            if (dec.wr_lo) lo_q <= opa;
            if (dec.rd_hi) begin rdv_q <= 1'b1; rdd_q <= hi_q; end
            if (dec.rd_lo) begin rdv_q <= 1'b1; rdd_q <= lo_q; end
         end
      end
   end

   assign busy     = busy_q;
   assign hi       = hi_q;
   assign lo       = lo_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;

   logic [CW:0] age_q;
   always_ff @(posedge clk) begin
      if (rst || !busy_q) age_q <= '0;
      else                age_q <= age_q + 1'b1;
   end

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_q) |-> (age_q == (CW+1)'(WIDTH))); // R6

   AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
      busy_q |=> (!busy_q || ($stable(hi_q) && $stable(lo_q)))); // R6

   AST_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      rdv_q |-> !busy_q); // R9

   AST_MOVE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
      (start && !busy_q && (func[5:2] != 4'b0110)) |=> !busy_q); // R10

endmodule

// File: tb/mdu_hilo_tb.sv
module mdu_hilo_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [5:0]    func = '0;
   logic [W-1:0]  opa = '0;
   logic [W-1:0]  opb = '0;
   logic          busy;
   logic [W-1:0]  hi;
   logic [W-1:0]  lo;
   logic          rd_valid;
   logic [W-1:0]  rd_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdu_hilo #(.WIDTH(W)) u_dut (
      .clk(clk), .rst(rst), .start(start), .func(func), .opa(opa), .opb(opb),
      .busy(busy), .hi(hi), .lo(lo), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    cmp_on = 1'b0;
   string cur_req = "R1";

   task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Behavioural reference model
   bit           m_busy, m_pend, m_pend_hi, m_rdv, m_dz, m_dz_sync;
   int           m_cnt;
   logic [W-1:0] m_hi, m_lo, m_rhi, m_rlo, m_rdd;

   task automatic compute(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [63:0] p;
      longint      q, r;
      m_dz = 1'b0;
      case (f)
         6'b011000: begin p = 64'(longint'($signed(a)) * longint'($signed(b))); m_rhi = p[63:32]; m_rlo = p[31:0]; end
         6'b011001: begin p = {32'b0, a} * {32'b0, b}; m_rhi = p[63:32]; m_rlo = p[31:0]; end
         6'b011010: begin
            if (b == 0) m_dz = 1'b1;
            else begin
               q = longint'($signed(a)) / longint'($signed(b));
               r = longint'($signed(a)) % longint'($signed(b));
               m_rlo = q[31:0]; m_rhi = r[31:0];
            end
         end
         default: begin
            if (b == 0) m_dz = 1'b1;
            else begin m_rlo = a / b; m_rhi = a % b; end
         end
      endcase
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_busy = 0; m_pend = 0; m_pend_hi = 0; m_rdv = 0; m_dz = 0; m_dz_sync = 0;
         m_cnt = 0; m_hi = 0; m_lo = 0; m_rdd = 0;
      end else begin
         m_rdv = 0;
         if (m_busy) begin
            if (start && (func == 6'b010000 || func == 6'b010010)) begin
               m_pend = 1; m_pend_hi = (func == 6'b010000);
            end
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_hi = m_rhi; m_lo = m_rlo;
               if (m_pend) begin m_rdv = 1; m_rdd = m_pend_hi ? m_rhi : m_rlo; end
               m_pend = 0;
               if (m_dz) m_dz_sync = 1;
            end
         end else if (start) begin
            case (func)
               6'b011000, 6'b011001, 6'b011010, 6'b011011: begin
                  compute(func, opa, opb); m_busy = 1; m_cnt = W;
               end
               6'b010001: m_hi = opa;
               6'b010011: m_lo = opa;
               6'b010000: begin m_rdv = 1; m_rdd = m_hi; end
               6'b010010: begin m_rdv = 1; m_rdd = m_lo; end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         if (m_dz_sync) begin
            m_hi = hi; m_lo = lo; m_dz_sync = 0;
         end
         chk(cur_req, "busy", {31'b0, busy}, {31'b0, m_busy});
         chk(cur_req, "hi", hi, m_hi);
         chk(cur_req, "lo", lo, m_lo);
         chk(cur_req, "rd_valid", {31'b0, rd_valid}, {31'b0, m_rdv});
         if (m_rdv) chk(cur_req, "rd_data", rd_data, m_rdd);
      end
   end

   task automatic issue(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      start = 1'b1; func = f; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0; func = '0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
      issue(f, a, b);
      wait_idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      int span;
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("R1", "reset busy", {31'b0, busy}, 32'd0);
      chk("R1", "reset hi", hi, 32'd0);
      chk("R1", "reset lo", lo, 32'd0);
      chk("R1", "reset rd_valid", {31'b0, rd_valid}, 32'd0);
      rst = 1'b0;
      cmp_on = 1'b1;

      cur_req = "R2";
      run(6'b011001, 32'd7, 32'd9);
      run(6'b011001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      chk("R2", "multu max hi", hi, 32'hFFFF_FFFE);
      chk("R2", "multu max lo", lo, 32'h0000_0001);
      run(6'b011001, 32'h1234_5678, 32'h9ABC_DEF0);
      run(6'b011001, 32'd0, 32'hDEAD_BEEF);

      cur_req = "R3";
      run(6'b011000, 32'hFFFF_FFF9, 32'd9);
      chk("R3", "mult -7*9 lo", lo, 32'hFFFF_FFC1);
      chk("R3", "mult -7*9 hi", hi, 32'hFFFF_FFFF);
      run(6'b011000, 32'h8000_0000, 32'h8000_0000);
      run(6'b011000, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
      run(6'b011000, 32'd12345, 32'hFFFF_0000);

      cur_req = "R4";
      run(6'b011011, 32'd100, 32'd7);
      chk("R4", "divu quotient", lo, 32'd14);
      chk("R4", "divu remainder", hi, 32'd2);
      run(6'b011011, 32'd3, 32'd10);
      run(6'b011011, 32'hFFFF_FFFF, 32'd1);
      run(6'b011011, 32'hF000_0001, 32'h0001_0003);

      cur_req = "R5";
      run(6'b011010, 32'hFFFF_FFF9, 32'd2);
      chk("R5", "div -7/2 quotient", lo, 32'hFFFF_FFFD);
      chk("R5", "div -7/2 remainder", hi, 32'hFFFF_FFFF);
      run(6'b011010, 32'd7, 32'hFFFF_FFFE);
      run(6'b011010, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
      run(6'b011010, 32'h8000_0000, 32'hFFFF_FFFF);

      cur_req = "R6";
      issue(6'b011001, 32'd5, 32'd6);
      span = 1;
      while (busy) begin @(negedge clk); if (busy) span++; end
      chk("R6", "busy span", span, 32'd32);
      @(negedge clk);

      cur_req = "R7";
      run(6'b010001, 32'hA5A5_0001, 32'd0);
      run(6'b010011, 32'h5A5A_0002, 32'd0);
      chk("R7", "hi after load", hi, 32'hA5A5_0001);
      chk("R7", "lo after load", lo, 32'h5A5A_0002);

      cur_req = "R8";
      issue(6'b010000, 32'd0, 32'd0);
      chk("R8", "rd hi valid", {31'b0, rd_valid}, 32'd1);
      chk("R8", "rd hi data", rd_data, 32'hA5A5_0001);
      issue(6'b010010, 32'd0, 32'd0);
      chk("R8", "rd lo data", rd_data, 32'h5A5A_0002);
      @(negedge clk);

      cur_req = "R9";
      issue(6'b011001, 32'h0001_0000, 32'h0003_0000);
      repeat (3) @(negedge clk);
      issue(6'b010000, 32'd0, 32'd0);
      while (!rd_valid) @(negedge clk);
      chk("R9", "held read data", rd_data, 32'h0000_0003);
      @(negedge clk);
      issue(6'b011001, 32'd11, 32'd13);
      repeat (30) @(negedge clk);
      issue(6'b010010, 32'd0, 32'd0);
      chk("R9", "last-cycle read data", rd_data, 32'd143);
      @(negedge clk);

      cur_req = "R10";
      issue(6'b011001, 32'd20, 32'd30);
      issue(6'b010001, 32'hDEAD_0000, 32'd0);
      issue(6'b010011, 32'hBEEF_0000, 32'd0);
      issue(6'b011011, 32'd1, 32'd1);
      wait_idle();
      chk("R10", "ignored move hi", hi, 32'd0);
      chk("R10", "ignored move lo", lo, 32'd600);
      issue(6'b100000, 32'h1111_1111, 32'h2222_2222);
      chk("R10", "unknown code busy", {31'b0, busy}, 32'd0);
      issue(6'b111111, 32'h1111_1111, 32'h2222_2222);
      chk("R10", "unknown code lo", lo, 32'd600);

      cur_req = "R11";
      issue(6'b011011, 32'd77, 32'd0);
      span = 1;
      while (busy) begin @(negedge clk); if (busy) span++; end
      chk("R11", "div by zero span", span, 32'd32);
      @(negedge clk);
      issue(6'b011010, 32'hFFFF_0000, 32'd0);
      wait_idle();
      run(6'b011001, 32'd3, 32'd4);
      chk("R11", "op after div by zero", lo, 32'd12);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule